// File: doc/BRIEF.md
# Address-Wakeup Serial Receiver

This block receives asynchronous serial frames. Each frame has one extra bit, the wakeup bit, that marks it as an address frame (bit = 1) or a data frame (bit = 0). A frame is one low start bit, `DATA_W` data bits sent least significant bit first, the wakeup bit, and one high stop bit. A separate baud tick runs at `OSR` times the bit rate. After the line passes a two-stage synchronizer, the receiver samples each bit at the centre of its window.

Software uses wakeup mode to skip traffic meant for other nodes. Setting the wakeup-wait bit makes the receiver discard data frames without any trace: no data transfer, no error detection, no flag changes and no interrupts. The first address frame ends the wait. The block clears the wakeup-wait bit by itself and handles that frame as a normal reception. Status flags are cleared by a clear strobe. Each interrupt output is gated by its own enable.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset, `wake_en`, `rx_full`, `frm_err`, `ovr_err`, `mpb_flag`, `rx_data`, `rxi_irq` and `eri_irq` are all 0.
- R2: In normal mode, a frame with a high stop bit received while `rx_full` is 0 loads its data bits into `rx_data` (first serial bit in bit 0) and sets `rx_full`. `mpb_flag` takes the wakeup bit of every frame that is not discarded.
- R3: While `wake_en` is 1, a frame whose wakeup bit is 0 leaves `rx_data` and `mpb_flag` unchanged.
- R4: While `wake_en` is 1, a frame whose wakeup bit is 0 sets none of `rx_full`, `frm_err` or `ovr_err`, even if its stop bit is low or `rx_full` is already set.
- R5: While `wake_en` is 1, `rxi_irq` and `eri_irq` are both 0.
- R6: A frame whose wakeup bit is 1 that arrives while `wake_en` is 1 clears `wake_en`, sets `mpb_flag`, and is otherwise handled exactly as in normal mode, error flags included.
- R7: A cycle with `wake_wr` high loads `wake_wdata` into `wake_en`, so software can both arm and cancel the wait.
- R8: A non-discarded frame whose stop bit is sampled low, received while `rx_full` is 0, sets `frm_err` and does not change `rx_data` or `rx_full`. The receiver then looks for a new start bit only after the line has returned high.
- R9: A non-discarded frame that completes while `rx_full` is 1 sets `ovr_err` and leaves `rx_data` unchanged.
- R10: A `flag_clr` pulse clears `rx_full`, `frm_err` and `ovr_err`. It leaves `mpb_flag` and `rx_data` unchanged.
- R11: `rxi_irq` equals `rie & rx_full` and `eri_irq` equals `eie & (frm_err | ovr_err)` whenever `wake_en` is 0. An error interrupt therefore stays high until its flag is cleared.
- R12: A low pulse that is high again at the centre of the start bit is rejected, and no frame is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial input line, idle high |
| tick | input | 1 | Oversampling tick, `OSR` per bit |
| wake_wr | input | 1 | Write strobe for the wakeup-wait bit |
| wake_wdata | input | 1 | Value written to the wakeup-wait bit |
| rie | input | 1 | Receive interrupt enable |
| eie | input | 1 | Receive-error interrupt enable |
| flag_clr | input | 1 | Clears receive-full, framing and overrun flags |
| rx_data | output | DATA_W | Received data register |
| rx_full | output | 1 | Receive data register holds unread data |
| frm_err | output | 1 | Framing error flag |
| ovr_err | output | 1 | Overrun flag |
| mpb_flag | output | 1 | Wakeup bit of the last frame not discarded |
| wake_en | output | 1 | Wakeup-wait bit |
| rxi_irq | output | 1 | Receive interrupt |
| eri_irq | output | 1 | Receive-error interrupt |

## Verification
The bench sends data frames with bad stop bits while the receiver waits for an address. A design that still checks errors during the wait would raise `frm_err` or `ovr_err`. The bench also sends an address frame with `rx_full` already set. This must produce an overrun and clear the wait; a design that gave the wakeup frame special treatment would overwrite the data or leave `wake_en` set. Short glitches on an idle line test start-bit rejection, because a receiver that accepts them shifts garbage into the next frame. A low stop bit followed by a short high gap tests the break-recovery path, because a receiver that hunts for a start bit at once would lose the following frame.

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic              tick,
  input  logic              wake_wr,
  input  logic              wake_wdata,
  input  logic              rie,
  input  logic              eie,
  input  logic              flag_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              frm_err,
  output logic              ovr_err,
  output logic              mpb_flag,
  output logic              wake_en,
  output logic              rxi_irq,
  output logic              eri_irq
);
  localparam int CW = $clog2(OSR);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [BW-1:0] BLAST = BW'(DATA_W - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_MPB, S_STOP, S_BRK} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    bcnt;
  logic [DATA_W-1:0] sh;
  logic             mpb_s;
  logic [1:0]       sync;
  logic             rx_s;
  logic             bit_end, done, accept, load;

  assign rx_s    = sync[1];
  assign bit_end = tick && (cnt == LAST);
  assign done    = bit_end && (st == S_STOP);
  assign accept  = done && !(wake_en && !mpb_s);
  assign load    = accept && !rx_full && rx_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bcnt <= '0; sh <= '0; mpb_s <= 1'b0;
    end else if (tick) begin
      case (st)
        S_IDLE:
          if (!rx_s) begin st <= S_START; cnt <= '0; end
        S_START:
          if (cnt == MID) begin
            cnt  <= '0;
            bcnt <= '0;
            st   <= rx_s ? S_IDLE : S_DATA;
          end else cnt <= cnt + 1'b1;
        S_DATA:
          if (cnt == LAST) begin
            cnt <= '0;
            sh  <= {rx_s, sh[DATA_W-1:1]};
            if (bcnt == BLAST) st <= S_MPB;
            else bcnt <= bcnt + 1'b1;
          end else cnt <= cnt + 1'b1;
        S_MPB:
          if (cnt == LAST) begin
            cnt <= '0; mpb_s <= rx_s; st <= S_STOP;
          end else cnt <= cnt + 1'b1;
        S_STOP:
          if (cnt == LAST) begin
            cnt <= '0; st <= rx_s ? S_IDLE : S_BRK;
          end else cnt <= cnt + 1'b1;
        S_BRK:
          if (rx_s) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0; rx_full <= 1'b0; frm_err <= 1'b0;
      ovr_err <= 1'b0; mpb_flag <= 1'b0; wake_en <= 1'b0;
    end else begin
      rx_full <= load | (rx_full & ~flag_clr);
      frm_err <= (accept & ~rx_full & ~rx_s) | (frm_err & ~flag_clr);
      ovr_err <= (accept & rx_full) | (ovr_err & ~flag_clr);
      if (load)   rx_data  <= sh;
      if (accept) mpb_flag <= mpb_s;
      if (accept && wake_en) wake_en <= 1'b0;
      else if (wake_wr)      wake_en <= wake_wdata;
    end
  end

  assign rxi_irq = rie & rx_full & ~wake_en;
  assign eri_irq = eie & (frm_err | ovr_err) & ~wake_en;
endmodule

// File: rtl/mp_uart_rx_chk.sv
module mp_uart_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wake_wr,
  input logic              rie,
  input logic              eie,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_full,
  input logic              frm_err,
  input logic              ovr_err,
  input logic              mpb_flag,
  input logic              wake_en,
  input logic              rxi_irq,
  input logic              eri_irq
);
  p_wait_keeps_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wake_en |=> ($stable(rx_data) || $fell(wake_en)));

  p_wait_no_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wake_en |=> ((!$rose(rx_full) && !$rose(frm_err) && !$rose(ovr_err)) || $fell(wake_en)));

  p_wait_irq_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_en |-> (!rxi_irq && !eri_irq));

  p_hw_wake_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(wake_en) && !$past(wake_wr)) |-> mpb_flag);

  p_ovr_keeps_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_err) |-> $stable(rx_data));

  p_rxi_enable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rie |-> !rxi_irq);

  p_eri_enable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !eie |-> !eri_irq);
endmodule

bind mp_uart_rx mp_uart_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wake_wr(wake_wr), .rie(rie), .eie(eie),
  .rx_data(rx_data), .rx_full(rx_full), .frm_err(frm_err), .ovr_err(ovr_err),
  .mpb_flag(mpb_flag), .wake_en(wake_en), .rxi_irq(rxi_irq), .eri_irq(eri_irq)
);

// File: tb/sim_mp_uart_rx.sv
module sim_mp_uart_rx;
  localparam int DW = 8;
  localparam int BITCYC = 32;

  logic clk = 1'b0, rst_n = 1'b0, rxd = 1'b1, tick = 1'b0;
  logic wake_wr = 1'b0, wake_wdata = 1'b0, rie = 1'b0, eie = 1'b0, flag_clr = 1'b0;
  logic [DW-1:0] rx_data;
  logic rx_full, frm_err, ovr_err, mpb_flag, wake_en, rxi_irq, eri_irq;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] e_data;
  logic e_full, e_ferr, e_ovr, e_mpb, e_wake;

  mp_uart_rx #(.DATA_W(DW), .OSR(16)) u0 (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick(tick), .wake_wr(wake_wr),
    .wake_wdata(wake_wdata), .rie(rie), .eie(eie), .flag_clr(flag_clr),
    .rx_data(rx_data), .rx_full(rx_full), .frm_err(frm_err), .ovr_err(ovr_err),
    .mpb_flag(mpb_flag), .wake_en(wake_en), .rxi_irq(rxi_irq), .eri_irq(eri_irq));

  always #2 clk = ~clk;

  initial forever begin
    @(negedge clk);
    tick = ~tick;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_rxi();
    return rie & e_full & ~e_wake;
  endfunction

  function automatic logic exp_eri();
    return eie & (e_ferr | e_ovr) & ~e_wake;
  endfunction

  task automatic check_all(input string req);
    check({req, " rx_data"}, 32'(rx_data), 32'(e_data));
    check({req, " rx_full"}, 32'(rx_full), 32'(e_full));
    check({req, " frm_err"}, 32'(frm_err), 32'(e_ferr));
    check({req, " ovr_err"}, 32'(ovr_err), 32'(e_ovr));
    check({req, " mpb_flag"}, 32'(mpb_flag), 32'(e_mpb));
    check({req, " wake_en"}, 32'(wake_en), 32'(e_wake));
    check({"R11 ", req, " rxi_irq"}, 32'(rxi_irq), 32'(exp_rxi()));
    check({"R11 ", req, " eri_irq"}, 32'(eri_irq), 32'(exp_eri()));
  endtask

  task automatic model_frame(input logic [DW-1:0] d, input logic m, input logic stp);
    if (e_wake && !m) return;
    if (e_wake) e_wake = 1'b0;
    e_mpb = m;
    if (e_full) e_ovr = 1'b1;
    else if (!stp) e_ferr = 1'b1;
    else begin e_data = d; e_full = 1'b1; end
  endtask

  task automatic send_bit(input logic b);
    rxd = b;
    repeat (BITCYC) @(negedge clk);
  endtask

  task automatic send_frame(input logic [DW-1:0] d, input logic m, input logic stp, input int gap);
    send_bit(1'b0);
    for (int i = 0; i < DW; i++) send_bit(d[i]);
    send_bit(m);
    send_bit(stp);
    rxd = 1'b1;
    repeat (gap) @(negedge clk);
    model_frame(d, m, stp);
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0; @(negedge clk);
    e_full = 1'b0; e_ferr = 1'b0; e_ovr = 1'b0;
  endtask

  task automatic write_wake(input logic v);
    wake_wr = 1'b1; wake_wdata = v; @(negedge clk); wake_wr = 1'b0; @(negedge clk);
    e_wake = v;
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd7351));
    e_data = '0; e_full = 0; e_ferr = 0; e_ovr = 0; e_mpb = 0; e_wake = 0;
    repeat (5) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rie = 1'b1; eie = 1'b1;

    send_frame(8'hA5, 1'b0, 1'b1, 40); check_all("R2 normal frame");
    send_frame(8'h3C, 1'b0, 1'b1, 40); check_all("R9 overrun keeps data");
    pulse_clr(); check_all("R10 clear keeps data and mpb");
    send_frame(8'h81, 1'b1, 1'b1, 40); check_all("R2 address frame normal");
    pulse_clr();

    rxd = 1'b0; repeat (8) @(negedge clk); rxd = 1'b1; repeat (60) @(negedge clk);
    check_all("R12 glitch rejected");
    send_frame(8'h5A, 1'b0, 1'b1, 40); check_all("R12 next frame intact");
    pulse_clr();

    send_frame(8'hF0, 1'b0, 1'b0, 6); check_all("R8 framing error");
    send_frame(8'h69, 1'b0, 1'b1, 40); check_all("R8 recover after low stop");
    pulse_clr();

    write_wake(1'b1); check_all("R7 arm wake");
    send_frame(8'h11, 1'b0, 1'b1, 40); check_all("R3 data frame discarded");
    send_frame(8'h22, 1'b0, 1'b0, 40); check_all("R4 bad stop ignored");
    check("R5 irq quiet while waiting", 32'({rxi_irq, eri_irq}), 32'd0);
    send_frame(8'h47, 1'b1, 1'b1, 40); check_all("R6 wakeup frame loads");
    write_wake(1'b1);
    send_frame(8'h99, 1'b1, 1'b1, 40); check_all("R6 wakeup frame with full is overrun");
    pulse_clr();
    write_wake(1'b1);
    send_frame(8'h77, 1'b1, 1'b0, 40); check_all("R6 wakeup frame framing error");
    pulse_clr();
    write_wake(1'b1); write_wake(1'b0); check_all("R7 software cancel");
    send_frame(8'h0F, 1'b0, 1'b1, 40); check_all("R7 normal after cancel");
    pulse_clr();

    for (int k = 0; k < 60; k++) begin
      logic [DW-1:0] d;
      logic m, stp;
      d = DW'($urandom);
      m = ($urandom % 3) == 0;
      stp = ($urandom % 8) != 0;
      if (($urandom % 4) == 0) write_wake(1'b1);
      if (($urandom % 3) == 0) pulse_clr();
      rie = $urandom; eie = $urandom;
      @(negedge clk);
      send_frame(d, m, stp, 40);
      check_all(e_wake ? "R3 R4 R5 random waiting" : "R2 R6 R8 R9 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule